// File: doc/BRIEF.md
# Capability Slot Table Controller

This block holds a table of capability words, one per numbered slot, and serves one command at a time from a requester. A capability word is an opaque, non-zero 18-bit value. An all-zero slot is empty. The commands are create, delete, read, exchange, copy and count, plus two commands that switch a protected mode on or off. Each command returns three things: a result value, a capability word and a success (skip) flag.

The usable index range depends on the protected mode. With the mode off, only the low slots can be used. With it on, the whole table is usable. Switching the mode off empties every slot above the low range. When create or copy names index 0, the block hunts for a free slot. It tests one slot per clock cycle, going upward from index 1, and it raises its acknowledge only once the outcome is known. When a target slot is taken, the block reports the word already held there.

Top module: `cap_table_ctrl`

## Requirements
- R1: After reset every slot is empty, protected mode is off, `ack` and `rsp_skip` are low, and count returns 0.
- R2: With protected mode off, only indices below 16 are usable. Any command that names an index of 16 or more through `req_idx_a` or `req_idx_b` treats that index as unusable: create and copy fail with a zero word, exchange fails with no change, and read returns 0. Protected-mode-on (code 6) makes all 64 indices usable.
- R3: Protected-mode-off (code 7) empties every slot at indices 16 to 63 and leaves slots 0 to 15 unchanged. Its skip flag is 1.
- R4: Create (code 0) to an explicit, usable, free index stores `req_word` there. It returns that index in `rsp_val` bits 5:0 with bits 17:6 zero, returns the stored word in `rsp_cap`, and sets skip.
- R5: Create or copy with `req_idx_a` = 0 picks the lowest free index from 1 up to the highest usable index. The search tests one slot per cycle, so `ack` comes p+1 cycles after the request when the first free slot is p. `ack` is never high while the search is running.
- R6: When the target slot is occupied, create or copy fails. It returns the occupant's word in `rsp_cap`, returns 0 in `rsp_val` and clears skip, and the table does not change. When an index-0 search finds no free slot, the word at the highest usable index is returned.
- R7: A create whose target is free fails with `rsp_cap` = 0 and skip clear when `req_nores` is high or `req_word` is zero. The table does not change.
- R8: Delete (code 1) empties the named usable slot and sets skip. Deleting an empty slot changes nothing.
- R9: Read (code 2) returns the slot's word in `rsp_val`, or 0 when the slot is empty, and sets skip.
- R10: Exchange (code 3) swaps the words at `req_idx_a` and `req_idx_b`. Either or both may be empty, and the two indices may be equal. Skip is set when both indices are usable.
- R11: Copy (code 4) writes the word at source `req_idx_b` into destination `req_idx_a`, or into the first free index when the destination is 0. It returns the destination index and the word and sets skip. It fails with a zero word when the source is empty or unusable and the destination is free.
- R12: Count (code 5) returns in `rsp_val` the number of occupied slots.
- R13: Each accepted request produces a one-cycle `ack` pulse. A command with an explicit index acks on the cycle after the request. The response outputs hold until the next `ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted when no search is running |
| req_cmd | input | 3 | Command code (0 create, 1 delete, 2 read, 3 exchange, 4 copy, 5 count, 6 protect on, 7 protect off) |
| req_idx_a | input | 6 | Target or destination index (0 asks for a search on create and copy) |
| req_idx_b | input | 6 | Copy source or second exchange index |
| req_word | input | 18 | Capability word for create |
| req_nores | input | 1 | Resource shortage: create must fail |
| ack | output | 1 | One-cycle completion pulse |
| rsp_val | output | 18 | Index, read word or count |
| rsp_cap | output | 18 | Stored, occupant or zero word |
| rsp_skip | output | 1 | Success flag |

## Verification
The bench targets several corner cases:
- A search that finds the table full. A design that stops short there returns the wrong word, or never acks.
- A search that must skip slot 0. A design that does not skip it can hand out slot 0.
- Exchange of two empty slots, and exchange of a slot with itself. A faulty swap path can corrupt a slot in either case.
- Switching the mode off. Clearing too far destroys slot 15, and clearing too little leaves high slots readable.
- Latency. Every acknowledge latency is compared with the first free index, so a search that tests more or fewer than one slot per cycle shows up.

// File: rtl/cap_table_pkg.sv
package cap_table_pkg;

    localparam int CAP_W = 18;

    typedef enum logic [2:0] {
        CMD_CREATE   = 3'd0,
        CMD_DELETE   = 3'd1,
        CMD_READ     = 3'd2,
        CMD_EXCHANGE = 3'd3,
        CMD_COPY     = 3'd4,
        CMD_COUNT    = 3'd5,
        CMD_PROT_ON  = 3'd6,
        CMD_PROT_OFF = 3'd7
    } cmd_e;

    typedef struct packed {
        logic [CAP_W-1:0] val;
        logic [CAP_W-1:0] cap;
        logic             skip;
    } resp_t;

    function automatic logic wants_search(input cmd_e c, input logic idx_zero);
        return idx_zero && (c == CMD_CREATE || c == CMD_COPY);
    endfunction

endpackage

// File: rtl/cap_slot_store.sv
module cap_slot_store #(
    parameter int NUM_SLOTS = 64,
    parameter int LOW_SLOTS = 16,
    parameter int W         = 18,
    parameter int IW        = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we0,
    input  logic [IW-1:0]        wi0,
    input  logic [W-1:0]         wd0,
    input  logic                 we1,
    input  logic [IW-1:0]        wi1,
    input  logic [W-1:0]         wd1,
    input  logic                 purge,
    input  logic [IW-1:0]        ra_idx,
    input  logic [IW-1:0]        rb_idx,
    output logic [W-1:0]         ra_data,
    output logic [W-1:0]         rb_data,
    output logic [NUM_SLOTS-1:0] occ
);
    logic [W-1:0] mem [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        localparam bit UPPER = (g >= LOW_SLOTS);
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[g] <= '0;
            end else if (purge && UPPER) begin
                mem[g] <= '0;
            end else if (we1 && wi1 == IW'(g)) begin
                mem[g] <= wd1;
            end else if (we0 && wi0 == IW'(g)) begin
                mem[g] <= wd0;
            end
        end
        assign occ[g] = |mem[g];
    end

    assign ra_data = mem[ra_idx];
    assign rb_data = mem[rb_idx];

    assert_purge_clears_R3: assert property (@(posedge clk) disable iff (rst)
        purge |=> ((occ >> LOW_SLOTS) == '0));

endmodule

// File: rtl/cap_free_scan.sv
module cap_free_scan #(
    parameter int NUM_SLOTS = 64,
    parameter int IW        = $clog2(NUM_SLOTS),
    parameter int LW        = $clog2(NUM_SLOTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [LW-1:0]        limit,
    input  logic [NUM_SLOTS-1:0] occ,
    output logic                 busy,
    output logic                 done,
    output logic [IW-1:0]        idx
);
    logic [IW-1:0] ptr_q;
    logic          at_top;

    assign at_top = (LW'(ptr_q) == limit - LW'(1));
    assign done   = busy && (!occ[ptr_q] || at_top);
    assign idx    = ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            ptr_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            ptr_q <= IW'(1);
        end else if (done) begin
            busy  <= 1'b0;
        end else if (busy) begin
            ptr_q <= ptr_q + IW'(1);
        end
    end

    assert_scan_in_range_R5: assert property (@(posedge clk) disable iff (rst)
        busy |-> (ptr_q != '0) && (LW'(ptr_q) < limit));

endmodule

// File: rtl/cap_popcount.sv
module cap_popcount #(
    parameter int N  = 64,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  bits_in,
    output logic [CW-1:0] total
);
    always_comb begin
        total = '0;
        for (int i = 0; i < N; i++) begin
            total = total + CW'(bits_in[i]);
        end
    end
endmodule

// File: rtl/cap_table_ctrl.sv
module cap_table_ctrl
    import cap_table_pkg::*;
#(
    parameter int NUM_SLOTS = 64,
    parameter int LOW_SLOTS = 16,
    parameter int IW        = $clog2(NUM_SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [2:0]       req_cmd,
    input  logic [IW-1:0]    req_idx_a,
    input  logic [IW-1:0]    req_idx_b,
    input  logic [CAP_W-1:0] req_word,
    input  logic             req_nores,
    output logic             ack,
    output logic [CAP_W-1:0] rsp_val,
    output logic [CAP_W-1:0] rsp_cap,
    output logic             rsp_skip
);
    localparam int LW = $clog2(NUM_SLOTS + 1);

    logic                 prot_q, prot_nxt;
    cmd_e                 cmd_q, cmd_last_q, op_cmd;
    logic [IW-1:0]        b_q, op_a, op_b;
    logic [CAP_W-1:0]     word_q, op_word;
    logic                 nores_q, op_nores;
    logic                 scan_busy, scan_done;
    logic [IW-1:0]        scan_idx;
    logic [LW-1:0]        limit, count;
    logic [NUM_SLOTS-1:0] occ;
    logic [CAP_W-1:0]     ra_data, rb_data;
    logic                 accept, start_scan, exec, in_a, in_b;
    logic                 we0, we1, purge_c;
    logic [CAP_W-1:0]     wd0, wd1;
    resp_t                nxt, rsp_q;

    assign limit      = prot_q ? LW'(NUM_SLOTS) : LW'(LOW_SLOTS);
    assign accept     = req_valid && !scan_busy;
    assign start_scan = accept && wants_search(cmd_e'(req_cmd), req_idx_a == '0);
    assign exec       = (accept && !start_scan) || scan_done;

    assign op_cmd   = scan_busy ? cmd_q   : cmd_e'(req_cmd);
    assign op_a     = scan_busy ? scan_idx : req_idx_a;
    assign op_b     = scan_busy ? b_q     : req_idx_b;
    assign op_word  = scan_busy ? word_q  : req_word;
    assign op_nores = scan_busy ? nores_q : req_nores;
    assign in_a     = LW'(op_a) < limit;
    assign in_b     = LW'(op_b) < limit;

    cap_slot_store #(.NUM_SLOTS(NUM_SLOTS), .LOW_SLOTS(LOW_SLOTS), .W(CAP_W), .IW(IW)) store_i (
        .clk(clk), .rst(rst),
        .we0(we0), .wi0(op_a), .wd0(wd0),
        .we1(we1), .wi1(op_b), .wd1(wd1),
        .purge(purge_c),
        .ra_idx(op_a), .rb_idx(op_b),
        .ra_data(ra_data), .rb_data(rb_data),
        .occ(occ)
    );

    cap_free_scan #(.NUM_SLOTS(NUM_SLOTS), .IW(IW), .LW(LW)) scan_i (
        .clk(clk), .rst(rst), .start(start_scan), .limit(limit), .occ(occ),
        .busy(scan_busy), .done(scan_done), .idx(scan_idx)
    );

    cap_popcount #(.N(NUM_SLOTS), .CW(LW)) count_i (.bits_in(occ), .total(count));

    always_comb begin
        nxt      = '0;
        we0      = 1'b0;
        wd0      = '0;
        we1      = 1'b0;
        wd1      = ra_data;
        purge_c  = 1'b0;
        prot_nxt = prot_q;
        if (exec) begin
            unique case (op_cmd)
                CMD_CREATE: begin
                    if (in_a && occ[op_a]) begin
                        nxt.cap = ra_data;
                    end else if (in_a && !op_nores && op_word != '0) begin
                        we0      = 1'b1;
                        wd0      = op_word;
                        nxt.val  = CAP_W'(op_a);
                        nxt.cap  = op_word;
                        nxt.skip = 1'b1;
                    end
                end
                CMD_COPY: begin
                    if (in_a && occ[op_a]) begin
                        nxt.cap = ra_data;
                    end else if (in_a && in_b && occ[op_b]) begin
                        we0      = 1'b1;
                        wd0      = rb_data;
                        nxt.val  = CAP_W'(op_a);
                        nxt.cap  = rb_data;
                        nxt.skip = 1'b1;
                    end
                end
                CMD_DELETE: begin
                    we0      = in_a;
                    nxt.skip = 1'b1;
                end
                CMD_READ: begin
                    nxt.val  = in_a ? ra_data : '0;
                    nxt.skip = 1'b1;
                end
                CMD_EXCHANGE: begin
                    if (in_a && in_b) begin
                        we0      = 1'b1;
                        wd0      = rb_data;
                        we1      = 1'b1;
                        nxt.skip = 1'b1;
                    end
                end
                CMD_COUNT: begin
                    nxt.val  = CAP_W'(count);
                    nxt.skip = 1'b1;
                end
                CMD_PROT_ON: begin
                    prot_nxt = 1'b1;
                    nxt.skip = 1'b1;
                end
                CMD_PROT_OFF: begin
                    prot_nxt = 1'b0;
                    purge_c  = 1'b1;
                    nxt.skip = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack        <= 1'b0;
            rsp_q      <= '0;
            prot_q     <= 1'b0;
            cmd_q      <= CMD_CREATE;
            cmd_last_q <= CMD_CREATE;
            b_q        <= '0;
            word_q     <= '0;
            nores_q    <= 1'b0;
        end else begin
            ack    <= exec;
            prot_q <= prot_nxt;
            if (exec) begin
                rsp_q      <= nxt;
                cmd_last_q <= op_cmd;
            end
            if (start_scan) begin
                cmd_q   <= cmd_e'(req_cmd);
                b_q     <= req_idx_b;
                word_q  <= req_word;
                nores_q <= req_nores;
            end
        end
    end

    assign rsp_val  = rsp_q.val;
    assign rsp_cap  = rsp_q.cap;
    assign rsp_skip = rsp_q.skip;

    assert_no_ack_during_search_R5: assert property (@(posedge clk) disable iff (rst)
        scan_busy |-> !ack);

    assert_upper_empty_when_off_R2: assert property (@(posedge clk) disable iff (rst)
        !prot_q |-> ((occ >> LOW_SLOTS) == '0));

    assert_created_slot_held_R4: assert property (@(posedge clk) disable iff (rst)
        (ack && rsp_skip && (cmd_last_q == CMD_CREATE || cmd_last_q == CMD_COPY))
        |-> ((rsp_val >> IW) == '0) && occ[rsp_val[IW-1:0]]);

    assert_failed_create_no_change_R6: assert property (@(posedge clk) disable iff (rst)
        (ack && !rsp_skip && cmd_last_q == CMD_CREATE) |-> (occ == $past(occ)));

endmodule

// File: tb/cap_table_ctrl_tb.sv
`timescale 1ns/1ps
module cap_table_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [2:0]  req_cmd;
    logic [5:0]  req_idx_a, req_idx_b;
    logic [17:0] req_word;
    logic        req_nores;
    logic        ack, rsp_skip;
    logic [17:0] rsp_val, rsp_cap;

    int checks = 0;
    int errors = 0;
    logic [17:0] m_mem [64];
    bit          m_prot;

    always #4 clk = ~clk;

    cap_table_ctrl dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_idx_a(req_idx_a), .req_idx_b(req_idx_b), .req_word(req_word),
        .req_nores(req_nores), .ack(ack), .rsp_val(rsp_val), .rsp_cap(rsp_cap),
        .rsp_skip(rsp_skip)
    );

    task automatic chk(input string tag, input string what, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic run_cmd(input int cmd, input int a, input int b, input logic [17:0] w,
                           input bit nores, input string tag);
        int limit, t, lat, n;
        bit auto_s;
        logic [17:0] ev, ec, tmp;
        logic es;
        limit  = m_prot ? 64 : 16;
        t      = a;
        lat    = 1;
        auto_s = (cmd == 0 || cmd == 4) && a == 0;
        if (auto_s) begin
            t = limit - 1;
            for (int k = limit - 1; k >= 1; k--) if (m_mem[k] == 0) t = k;
            lat = t + 1;
        end
        ev = 0; ec = 0; es = 0;
        case (cmd)
            0: if (t < limit) begin
                   if (m_mem[t] != 0) ec = m_mem[t];
                   else if (!nores && w != 0) begin m_mem[t] = w; ev = 18'(t); ec = w; es = 1; end
               end
            4: if (t < limit) begin
                   if (m_mem[t] != 0) ec = m_mem[t];
                   else if (b < limit && m_mem[b] != 0) begin
                       m_mem[t] = m_mem[b]; ev = 18'(t); ec = m_mem[b]; es = 1;
                   end
               end
            1: begin es = 1; if (t < limit) m_mem[t] = 0; end
            2: begin es = 1; if (t < limit) ev = m_mem[t]; end
            3: if (t < limit && b < limit) begin
                   tmp = m_mem[t]; m_mem[t] = m_mem[b]; m_mem[b] = tmp; es = 1;
               end
            5: begin es = 1; for (int k = 0; k < 64; k++) if (m_mem[k] != 0) ev++; end
            6: begin es = 1; m_prot = 1; end
            default: begin es = 1; m_prot = 0; for (int k = 16; k < 64; k++) m_mem[k] = 0; end
        endcase
        @(negedge clk);
        req_valid = 1; req_cmd = 3'(cmd); req_idx_a = 6'(a); req_idx_b = 6'(b);
        req_word = w; req_nores = nores;
        @(posedge clk); #1;
        req_valid = 0;
        n = 1;
        while (!ack && n < 200) begin @(posedge clk); #1; n++; end
        if (!ack) begin
            errors++; checks++;
            $display("FAIL %s watchdog: actual no ack expected ack", tag);
            return;
        end
        chk(auto_s ? "R5" : "R13", "latency", 18'(n), 18'(lat));
        chk(tag, "rsp_val", rsp_val, ev);
        chk(tag, "rsp_cap", rsp_cap, ec);
        chk(tag, "rsp_skip", 18'(rsp_skip), 18'(es));
        @(posedge clk); #1;
        chk("R13", "ack pulse", 18'(ack), 18'(0));
        chk("R13", "rsp hold", rsp_val, ev);
    endtask

    task automatic sweep_read(input string tag);
        for (int k = 0; k < 64; k++) run_cmd(2, k, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 64; k++) m_mem[k] = 0;
        m_prot = 0;
        rst = 1; req_valid = 0; req_cmd = 0; req_idx_a = 0; req_idx_b = 0;
        req_word = 0; req_nores = 0;
        repeat (3) @(posedge clk); #1;
        rst = 0;
        chk("R1", "ack after reset", 18'(ack), 18'(0));
        chk("R1", "skip after reset", 18'(rsp_skip), 18'(0));
        run_cmd(5, 0, 0, 0, 0, "R1");
        sweep_read("R1");
        // R5: fill the low range by searching, then hit the full case (R6)
        for (int k = 1; k < 16; k++) run_cmd(0, 0, 0, 18'h1000 + 18'(k), 0, "R5");
        run_cmd(0, 0, 0, 18'h2abc, 0, "R6");
        // R2: upper indices unusable while protected mode is off
        run_cmd(0, 20, 0, 18'h0777, 0, "R2");
        run_cmd(2, 20, 0, 0, 0, "R2");
        run_cmd(3, 3, 20, 0, 0, "R2");
        run_cmd(2, 3, 0, 0, 0, "R2");
        // R8 delete, then search refills the hole
        run_cmd(1, 7, 0, 0, 0, "R8");
        run_cmd(1, 7, 0, 0, 0, "R8");
        run_cmd(2, 7, 0, 0, 0, "R9");
        run_cmd(0, 7, 0, 18'h0, 0, "R7");
        run_cmd(0, 7, 0, 18'h3111, 1, "R7");
        run_cmd(2, 7, 0, 0, 0, "R7");
        run_cmd(0, 7, 0, 18'h3111, 0, "R4");
        run_cmd(0, 3, 0, 18'h3222, 0, "R6");
        run_cmd(1, 9, 0, 0, 0, "R8");
        run_cmd(0, 0, 0, 18'h3999, 0, "R5");
        // protected mode on
        run_cmd(6, 0, 0, 0, 0, "R2");
        run_cmd(0, 40, 0, 18'h3f40, 0, "R4");
        run_cmd(0, 63, 0, 18'h3f63, 0, "R4");
        run_cmd(0, 0, 0, 18'h0016, 0, "R5");
        // R11 copy
        run_cmd(4, 0, 40, 0, 0, "R11");
        run_cmd(4, 30, 50, 0, 0, "R11");
        run_cmd(4, 63, 5, 0, 0, "R6");
        run_cmd(4, 45, 5, 0, 0, "R11");
        // R10 exchange
        run_cmd(3, 0, 5, 0, 0, "R10");
        run_cmd(2, 0, 0, 0, 0, "R10");
        run_cmd(2, 5, 0, 0, 0, "R10");
        run_cmd(3, 0, 0, 0, 0, "R10");
        run_cmd(3, 50, 51, 0, 0, "R10");
        run_cmd(3, 2, 33, 0, 0, "R10");
        run_cmd(5, 0, 0, 0, 0, "R12");
        sweep_read("R9");
        // R3 mode off purges upper slots
        run_cmd(7, 0, 0, 0, 0, "R3");
        run_cmd(2, 40, 0, 0, 0, "R3");
        run_cmd(5, 0, 0, 0, 0, "R12");
        sweep_read("R3");
        run_cmd(0, 17, 0, 18'h0123, 0, "R2");
        // fill the whole table by searching, then the full case at index 63
        run_cmd(6, 0, 0, 0, 0, "R2");
        for (int k = 0; k < 50; k++) run_cmd(0, 0, 0, 18'h20000 + 18'(k), 0, "R5");
        run_cmd(0, 0, 0, 18'h1, 0, "R6");
        run_cmd(4, 0, 1, 0, 0, "R6");
        run_cmd(5, 0, 0, 0, 0, "R12");
        sweep_read("R9");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule